// File: doc/BRIEF.md
# Successive-Approximation Ramp Calibrator with Smoothed Output

This block finds the pulse width at which an integrated positive ramp just reaches a reference voltage. It keeps an upper and a lower bound on that width and, each time it is started, advances the search by at most one step. A step asks an external pulse sequencer for one pulse at the midpoint of the range, and the comparator verdict at the end of that pulse halves the range. Between steps the sequencer is free to serve normal output traffic.

When the two bounds meet, the settled width is the new measurement. It is fed into a first-order exponential average with 24 bits of state, and the upper 16 bits of that average are the scale factor used by the rest of the converter. The first measurement loads the average directly and sets a sticky flag. Every invocation ends with a one-cycle done strobe.

Top module: `ramp_sar_cal`

## Requirements
- R1: After reset, pulse_req, done and first_done are 0 and scale is 0.
- R2: An invocation with no valid bounds sets top to 65535 and bottom to 0, marks them valid, requests no pulse, and raises done for exactly one cycle, in the cycle after start is sampled.
- R3: An invocation with valid, unequal bounds raises pulse_req for one cycle, in the cycle after start is sampled, with pulse_width = floor((top + bottom) / 2), and raises no done in that cycle.
- R4: When cmp_valid is sampled while a pulse is outstanding, cmp_above = 1 makes top equal the midpoint and cmp_above = 0 makes bottom equal the midpoint + 1. done is raised in the next cycle.
- R5: An invocation with equal bounds requests no pulse, pushes that value into the average, marks the bounds invalid, and raises done in the cycle after start is sampled.
- R6: The first push loads the average with the value times 256, so scale equals the value, and it sets first_done. first_done stays 1 until reset.
- R7: Each later push updates the 24-bit average as acc = acc + ((value*256 - acc) >>> SHIFT), with an arithmetic shift. SHIFT is a parameter from 0 to 15, default 3. scale is acc[23:8].
- R8: start while a pulse is outstanding, and cmp_valid while none is outstanding, are ignored. They produce no pulse, no done and no change to the bounds.
- R9: An invocation requests at most one pulse. pulse_req is never high in two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe that begins an invocation |
| pulse_req | output | 1 | One-cycle request to the sequencer for a tuning pulse |
| pulse_width | output | 16 | Width of the requested pulse in counts |
| cmp_valid | input | 1 | Comparator result is valid this cycle |
| cmp_above | input | 1 | 1 when the ramp ended above the reference |
| scale | output | 16 | Smoothed tuning scale factor |
| first_done | output | 1 | Sticky flag: at least one search has completed |
| done | output | 1 | One-cycle strobe at the end of each invocation |

## Verification
The assertions assume that start and cmp_valid are single-cycle strobes, and that the comparator answers a request only after pulse_req has been seen. The bench drives its inputs on falling edges. It delivers one comparator result per request, some cycles after the request, and its comparator model reports "above" exactly when the width is at or past a chosen threshold. The only out-of-protocol stimulus is in the ignore scenario: a stray start while a pulse is outstanding, and a stray cmp_valid while idle. That scenario checks at the ports that neither input has any effect.

// File: rtl/ramp_sar_cal.sv
module ramp_sar_cal #(
  parameter int unsigned W     = 16,
  parameter int unsigned FRAC  = 8,
  parameter int unsigned SHIFT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         pulse_req,
  output logic [W-1:0] pulse_width,
  input  logic         cmp_valid,
  input  logic         cmp_above,
  output logic [W-1:0] scale,
  output logic         first_done,
  output logic         done
);
  localparam int unsigned ACW = W + FRAC;

  logic [W-1:0]   top, bot;
  logic           bvalid, waiting;
  logic [ACW-1:0] acc;
  logic [W:0]     sum;
  logic [W-1:0]   mid;
  logic [ACW-1:0] xe;
  logic signed [ACW:0] diff, step;

  assign sum   = {1'b0, top} + {1'b0, bot};
  assign mid   = sum[W:1];
  assign xe    = {top, {FRAC{1'b0}}};
  assign diff  = $signed({1'b0, xe}) - $signed({1'b0, acc});
  assign step  = diff >>> SHIFT;
  assign scale = acc[ACW-1:FRAC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top <= '0; bot <= '0; bvalid <= 1'b0; waiting <= 1'b0;
      acc <= '0; first_done <= 1'b0; pulse_req <= 1'b0;
      pulse_width <= '0; done <= 1'b0;
    end else begin
      pulse_req <= 1'b0;
      done      <= 1'b0;
      if (waiting) begin
        if (cmp_valid) begin
          if (cmp_above) top <= pulse_width;
          else           bot <= pulse_width + 1'b1;
          waiting <= 1'b0;
          done    <= 1'b1;
        end
      end else if (start) begin
        if (!bvalid) begin
          top    <= '1;
          bot    <= '0;
          bvalid <= 1'b1;
          done   <= 1'b1;
        end else if (top == bot) begin
          if (!first_done) acc <= xe;
          else             acc <= acc + step[ACW-1:0];
          first_done <= 1'b1;
          bvalid     <= 1'b0;
          done       <= 1'b1;
        end else begin
          pulse_req   <= 1'b1;
          pulse_width <= mid;
          waiting     <= 1'b1;
        end
      end
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_req |=> !pulse_req); // R9
  AST_PULSE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_req |-> !done); // R3
  AST_WIDTH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_req |-> (pulse_width >= bot && pulse_width < top)); // R3
  AST_BOUNDS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> bot <= top); // R4
  AST_FIRST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    first_done |=> first_done); // R6
  AST_WAIT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !cmp_valid) |=> !pulse_req && !done); // R8
endmodule

// File: tb/tb_ramp_sar_cal.sv
module tb_ramp_sar_cal;
  localparam int SHIFT = 3;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cmp_valid = 1'b0, cmp_above = 1'b0;
  logic pulse_req, first_done, done;
  logic [15:0] pulse_width, scale;
  int total = 0, bad = 0;

  int mtop, mbot;
  bit mvalid = 0, mfirst = 0;
  logic [23:0] macc = '0;

  always #4 clk = ~clk;

  ramp_sar_cal #(.W(16), .FRAC(8), .SHIFT(SHIFT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pulse_req(pulse_req),
    .pulse_width(pulse_width), .cmp_valid(cmp_valid), .cmp_above(cmp_above),
    .scale(scale), .first_done(first_done), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fire_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic answer(input bit above);
    cmp_valid = 1'b1; cmp_above = above;
    @(negedge clk) cmp_valid = 1'b0;
  endtask

  // one invocation against a comparator threshold thr; returns 1 when a push happened
  task automatic step(input int thr, input bit stray, output bit pushed);
    int mid;
    logic signed [24:0] d;
    pushed = 0;
    fire_start();
    if (!mvalid) begin
      chk(!pulse_req, "R2", pulse_req, 0);
      chk(done, "R2", done, 1);
      mtop = 65535; mbot = 0; mvalid = 1;
      @(negedge clk) chk(!done, "R2", done, 0);
    end else if (mtop == mbot) begin
      chk(!pulse_req && done, "R5", {pulse_req, done}, 1);
      if (!mfirst) macc = 24'(mtop) << 8;
      else begin
        d = $signed({1'b0, 24'(mtop) << 8}) - $signed({1'b0, macc});
        macc = macc + 24'(d >>> SHIFT);
      end
      chk(scale == macc[23:8], mfirst ? "R7" : "R6", scale, macc[23:8]);
      mfirst = 1; mvalid = 0; pushed = 1;
      chk(first_done, "R6", first_done, 1);
    end else begin
      mid = (mtop + mbot) / 2;
      chk(pulse_req, "R3", pulse_req, 1);
      chk(pulse_width == mid, "R3", pulse_width, mid);
      chk(!done, "R3", done, 0);
      if (stray) begin
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(!pulse_req && !done, "R8", {pulse_req, done}, 0);
      end else begin
        @(negedge clk) chk(!pulse_req, "R9", pulse_req, 0);
      end
      @(negedge clk);
      answer(mid >= thr);
      chk(done, "R4", done, 1);
      if (mid >= thr) mtop = mid; else mbot = mid + 1;
    end
  endtask

  task automatic search(input int thr, input bit stray);
    bit p;
    int n = 0;
    do begin
      step(thr, stray && n == 3, p);
      n++;
    end while (!p && n < 40);
    chk(p, "R5", n, 18);
    chk(scale == macc[23:8], "R7", scale, macc[23:8]);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!pulse_req && !done && !first_done, "R1", {pulse_req, done, first_done}, 0);
    chk(scale == 0, "R1", scale, 0);
    rst_n = 1'b1;
  endtask

  task automatic test_idle_cmp();
    bit p;
    @(negedge clk) cmp_valid = 1'b1; cmp_above = 1'b1;
    @(negedge clk) cmp_valid = 1'b0;
    chk(!done && !pulse_req, "R8", {done, pulse_req}, 0);
    step(30000, 0, p);
  endtask

  initial begin
    test_reset();
    search(40000, 0);
    search(1000, 1);
    test_idle_cmp();
    search(65535, 0);
    search(0, 0);
    search(12345, 0);
    chk(first_done, "R6", first_done, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule